// File: doc/BRIEF.md
# Two-Bridge Fixed-Frequency Chopper Current Controller

This block regulates winding current in two full bridges by chopping their high-side (source) drivers. A free-running period counter produces a one-cycle tick at a fixed rate. On each tick, the source-enable latch of every enabled bridge is set. While a latch is set, current builds up in the winding. When that bridge's current-trip input rises, its latch is cleared and current recirculates until the next tick. Each bridge is cleared on its own, but all bridges are set together by the shared tick.

The trip inputs are synchronous and stand in for analog sense comparators. Every trip input is ignored for a blanking window after each source turn-on. It is also ignored for a separate, programmable window after any change on that bridge's polarity or enable input. A bypass input turns regulation off, so that each source enable simply follows its bridge enable. The period, turn-on blank and input-change blank are given as clock-cycle counts. They are loaded into configuration registers at reset.

Top module: `chop_ctrl`

## Requirements
- R1: When `period_tick_o` is high in a cycle, every bridge that is enabled (`bridge_on_i` = 1) and not bypassed has `src_en_o` high from the next clock edge.
- R2: `period_tick_o` is a single-cycle pulse every ON_CYCLES + BLANK_CYCLES cycles. It is first high after the ON_CYCLES + BLANK_CYCLES-th clock edge following reset release.
- R3: A trip on one bridge clears only that bridge's `src_en_o`, one edge after the trip is sampled outside blanking. The other bridge's output is unchanged.
- R4: After a source turn-on edge, `trip_i` is ignored for BLANK_CYCLES cycles. With the trip held high, `src_en_o` stays high for BLANK_CYCLES + 1 cycles.
- R5: A change of `phase_i` on an enabled bridge starts a blank of CHG_BLANK_CYCLES cycles, counted from that edge. If the blank already running is longer, the longer one is kept. A trip held from the change keeps `src_en_o` high for CHG_BLANK_CYCLES + 1 cycles.
- R6: Once cleared by a trip, `src_en_o` stays low until the edge after the next tick, even if `trip_i` falls.
- R7: While `bypass_i` is high, `src_en_o` equals the bridge's `bridge_on_i` of the previous cycle, whatever the trip input does.
- R8: A bridge with `bridge_on_i` = 0 has `src_en_o` low from the next edge. Re-enabling sets `src_en_o` at once and starts a blank of max(BLANK_CYCLES, CHG_BLANK_CYCLES) cycles.
- R9: If a tick and a trip fall in the same cycle, the tick wins. The latch is set and the turn-on blank starts.
- R10: During and right after reset, `src_en_o` and `period_tick_o` are low until the first tick takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | 1 = regulation off; sources follow enables |
| phase_i | input | NUM_BRIDGES | Per-bridge current polarity |
| bridge_on_i | input | NUM_BRIDGES | Per-bridge enable, 1 = drivers on |
| trip_i | input | NUM_BRIDGES | Per-bridge synchronous current-trip |
| period_tick_o | output | 1 | Registered one-cycle period tick |
| src_en_o | output | NUM_BRIDGES | Registered per-bridge source enable |

## Verification
The shared period tick and a bridge's own trip can reach the latch on the same clock edge, with set and clear competing. The bench sweeps the cycle in which the trip rises across the whole period, including the very cycle in which the tick is visible. It judges each case by the number of cycles the source stays high, computed as max(offset, BLANK_CYCLES + 1). A polarity change landing inside a running turn-on blank is provoked the same way. There the longer window must win.

// File: rtl/chop_pkg.sv
package chop_pkg;
  parameter int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t cnt_max(input cnt_t a, input cnt_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chop_period_gen.sv
module chop_period_gen
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t lim_i,
  output logic tick_o
);
  cnt_t cnt_q;
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == lim_i);
      cnt_q  <= (cnt_q == lim_i) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_i);
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  cnt_t load_val_i,
  output logic busy_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_max(cnt_q, load_val_i);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  p_busy_count_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_load_covers_r5: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q >= $past(load_val_i)));
endmodule

// File: rtl/chop_bridge_latch.sv
module chop_bridge_latch
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic bypass_i,
  input  logic on_i,
  input  logic phase_i,
  input  logic trip_i,
  input  cnt_t blank_len_i,
  input  cnt_t chg_len_i,
  output logic src_o
);
  logic on_d, ph_d, src_q;
  logic on_rise, chg, turn_on, blank_load, busy;
  cnt_t blank_val;

  always_comb begin
    on_rise    = on_i & ~on_d;
    chg        = (on_i != on_d) | (phase_i != ph_d);
    turn_on    = on_i & ~bypass_i & (tick_i | on_rise);
    blank_load = turn_on | (chg & on_i);
    if (turn_on && chg)  blank_val = cnt_max(blank_len_i, chg_len_i);
    else if (turn_on)    blank_val = blank_len_i;
    else                 blank_val = chg_len_i;
  end

  chop_blank_timer blank_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (blank_load),
    .load_val_i (blank_val),
    .busy_o     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      on_d  <= on_i;
      ph_d  <= phase_i;
      src_q <= 1'b0;
    end else begin
      on_d <= on_i;
      ph_d <= phase_i;
      if (!on_i)                        src_q <= 1'b0;
      else if (bypass_i)                src_q <= 1'b1;
      else if (turn_on)                 src_q <= 1'b1;
      else if (trip_i && !busy && !chg) src_q <= 1'b0;
    end
  end

  assign src_o = src_q;

  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !on_i |=> !src_q);
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(src_q) |-> $past(tick_i || bypass_i || on_rise));
  p_blank_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (src_q && busy && on_i && !bypass_i) |=> src_q);
  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && on_i) |=> src_q);
  p_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(src_q) |-> $past(!on_i || (trip_i && !bypass_i)));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned NUM_BRIDGES      = 2,
  parameter int unsigned ON_CYCLES        = 3870,
  parameter int unsigned BLANK_CYCLES     = 130,
  parameter int unsigned CHG_BLANK_CYCLES = 100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bypass_i,
  input  logic [NUM_BRIDGES-1:0] phase_i,
  input  logic [NUM_BRIDGES-1:0] bridge_on_i,
  input  logic [NUM_BRIDGES-1:0] trip_i,
  output logic                   period_tick_o,
  output logic [NUM_BRIDGES-1:0] src_en_o
);
  localparam int unsigned PERIOD_CYCLES = ON_CYCLES + BLANK_CYCLES;
  localparam cnt_t LIM_INIT   = cnt_t'(PERIOD_CYCLES - 1);
  localparam cnt_t BLANK_INIT = cnt_t'(BLANK_CYCLES);
  localparam cnt_t CHG_INIT   = cnt_t'(CHG_BLANK_CYCLES);

  cnt_t lim_q, blank_q, chg_q;
  logic tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= LIM_INIT;
      blank_q <= BLANK_INIT;
      chg_q   <= CHG_INIT;
    end
  end

  chop_period_gen period_i (
    .clk    (clk),
    .rst    (rst),
    .lim_i  (lim_q),
    .tick_o (tick)
  );

  assign period_tick_o = tick;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    chop_bridge_latch latch_i (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick),
      .bypass_i    (bypass_i),
      .on_i        (bridge_on_i[b]),
      .phase_i     (phase_i[b]),
      .trip_i      (trip_i[b]),
      .blank_len_i (blank_q),
      .chg_len_i   (chg_q),
      .src_o       (src_en_o[b])
    );
  end
endmodule

// File: tb/chop_ctrl_tb.sv
module chop_ctrl_tb_top;
  localparam int NB = 2;
  localparam int TON = 20;
  localparam int TBL = 5;
  localparam int TCH = 8;
  localparam int P = TON + TBL;
  localparam int TMAX = (TBL > TCH) ? TBL : TCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass = 1'b0;
  logic [NB-1:0] phase = '0;
  logic [NB-1:0] bon = '1;
  logic [NB-1:0] trip = '0;
  logic tick;
  logic [NB-1:0] src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chop_ctrl #(
    .NUM_BRIDGES(NB), .ON_CYCLES(TON), .BLANK_CYCLES(TBL), .CHG_BLANK_CYCLES(TCH)
  ) dut_i (
    .clk(clk), .rst(rst), .bypass_i(bypass), .phase_i(phase),
    .bridge_on_i(bon), .trip_i(trip), .period_tick_o(tick), .src_en_o(src)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    for (int k = 0; k < 3 * P; k++) begin
      @(negedge clk);
      if (tick) return;
    end
    check(1'b0, "R2 tick missing", 0, 1);
  endtask

  // Runs one period from a tick; bridge 0 trip rises at t==d (with optional
  // phase toggle). Returns number of high samples of src[0] from t=1.
  task automatic run_trip(input int d, input bit toggle, output int hi,
                          output bit low_ok, output bit other_ok, output int tnext);
    int tclr = 0;
    hi = 0; low_ok = 1'b1; other_ok = 1'b1; tnext = 0;
    if (d == 0) trip[0] = 1'b1;
    for (int t = 1; t <= 3 * P; t++) begin
      @(negedge clk);
      if (!src[1]) other_ok = 1'b0;
      if (tclr == 0) begin
        if (src[0]) hi++;
        else begin tclr = t; trip[0] = 1'b0; end
      end else if (src[0]) low_ok = 1'b0;
      if (tick) begin tnext = t; break; end
      if (t == d && d != 0) begin
        trip[0] = 1'b1;
        if (toggle) phase[0] = ~phase[0];
      end
    end
    trip[0] = 1'b0;
  endtask

  initial begin
    int hi, tn, exp;
    bit lo, oth, ok;
    repeat (3) @(negedge clk);
    check(src == '0 && !tick, "R10 reset state", int'(src), 0);
    rst = 1'b0;
    ok = 1'b1;
    for (int k = 1; k <= P; k++) begin
      @(negedge clk);
      if (k < P && (tick || src != '0)) ok = 1'b0;
      if (k == P) check(tick == 1'b1, "R2 first tick position", int'(tick), 1);
    end
    check(ok, "R10 quiet until first tick", 0, 1);

    // Sweep trip onset across the period (R3, R4, R6, R9, R1, R2)
    for (int d = 0; d <= P - 2; d++) begin
      run_trip(d, 1'b0, hi, lo, oth, tn);
      exp = (d > TBL + 1) ? d : TBL + 1;
      check(hi == exp, (d == 0) ? "R9 tick beats trip" : "R4 blanked high time", hi, exp);
      check(lo, "R6 stays off until next tick", 0, 1);
      check(oth, "R3 other bridge untouched", 0, 1);
      check(tn == P, "R2 tick spacing", tn, P);
    end
    @(negedge clk);
    check(src == 2'b11, "R1 both latches set after tick", int'(src), 3);
    wait_tick();

    // Phase change blanking (R5)
    foreach (ok_d[i]) begin
      run_trip(ok_d[i], 1'b1, hi, lo, oth, tn);
      check(hi == ok_d[i] + TCH + 1, "R5 change blank", hi, ok_d[i] + TCH + 1);
      check(oth, "R3 other bridge untouched", 0, 1);
    end

    // Disable / re-enable (R8)
    begin
      int cnt = 0;
      bit seen_low = 1'b0;
      for (int t = 1; t <= P - 1; t++) begin
        @(negedge clk);
        if (t == 4) check(src[0] == 1'b0, "R8 disabled clears", int'(src[0]), 0);
        if (t >= 7 && !seen_low) begin
          if (src[0]) cnt++; else seen_low = 1'b1;
        end
        if (t == 3) bon[0] = 1'b0;
        if (t == 6) begin bon[0] = 1'b1; trip[0] = 1'b1; end
      end
      check(cnt == TMAX + 1, "R8 re-enable blank", cnt, TMAX + 1);
      trip[0] = 1'b0;
      wait_tick();
    end

    // Bypass (R7)
    bypass = 1'b1;
    trip = '1;
    ok = 1'b1;
    for (int t = 1; t <= 2 * P; t++) begin
      @(negedge clk);
      if (src != 2'b11) ok = 1'b0;
    end
    check(ok, "R7 bypass keeps sources on", int'(src), 3);
    bon[1] = 1'b0;
    @(negedge clk);
    check(src == 2'b01, "R7 bypass follows enable", int'(src), 1);
    bon[1] = 1'b1;
    @(negedge clk);
    check(src == 2'b11, "R7 bypass re-enable", int'(src), 3);
    bypass = 1'b0;
    trip = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int ok_d [3] = '{2, 10, 12};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule